// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table that lives in memory. When a miss is accepted, the virtual address is split into an outer index, an inner index and a byte offset. The outer table sits at a base address supplied on an input and captured when the walk starts. That table is always resident, so the walk never has to translate the address of a table entry.

The walker reads the outer entry. If the entry is present, its frame field locates an inner table, and the walker reads the inner entry there. A present inner entry yields the frame number and attribute bits, which are pulsed to the fill port together with the full physical address. An empty entry at either level ends the walk with a fault pulse. The fault names the virtual address and the level that was empty. Inner tables are created on demand by software, so an empty outer entry ends the walk at once, without a second read.

Memory is reached through a read port that has a request/ready handshake and a response valid. Only one walk runs at a time, and the busy output tells the requester to hold off.

Top module: `tbl_walker`

## Requirements
- R1: While reset is held, busy, mem_req_valid, fill_valid and fault_valid are all low.
- R2: The first read of a walk goes to root_base + miss_va[31:22] × 4. root_base is the value present in the cycle the miss is accepted.
- R3: The second read goes to {outer_entry[31:12], 12'h000} + miss_va[21:12] × 4.
- R4: A table entry carries its present flag in bit 0, four attribute bits in bits 4:1 and the frame number in bits 31:12. When both entries are present, fill_valid pulses with the following values:
  - fill_pfn is the inner entry's bits 31:12.
  - fill_attr is its bits 4:1.
  - fill_vpn is miss_va[31:12].
  - fill_pa is {fill_pfn, miss_va[11:0]}.
- R5: An outer entry with bit 0 clear ends the walk after exactly one read. fault_valid pulses with fault_level 0 and fault_va equal to the missing address.
- R6: An inner entry with bit 0 clear ends the walk after exactly two reads. fault_valid pulses with fault_level 1 and fault_va equal to the missing address.
- R7: busy rises in the cycle after a miss is accepted and stays high through the cycle of the result pulse. A miss presented while busy is ignored: it causes no extra read and does not change the result of the walk in progress.
- R8: Once raised, mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is seen.
- R9: fill_valid and fault_valid are never high together. Each lasts exactly one cycle, after which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Translation miss request, taken while idle |
| miss_va | input | 32 | Virtual address that missed |
| root_base | input | 32 | Byte address of the outer table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |
| fill_valid | output | 1 | Translation result pulse |
| fill_vpn | output | 20 | Virtual page number of the result |
| fill_pfn | output | 20 | Frame number of the result |
| fill_attr | output | 4 | Attribute bits of the result |
| fill_pa | output | 32 | Physical address: frame joined with offset |
| fault_valid | output | 1 | Page fault pulse |
| fault_va | output | 32 | Faulting virtual address |
| fault_level | output | 1 | Empty level: 0 outer, 1 inner |

## Verification
The bench builds the walker with its default split: 10 outer bits, 10 inner bits and a 12-bit offset, with 32-bit entries of four bytes each and four attribute bits. At this size the all-ones index selects the last entry of a table at offset 0xFFC, and the offset field is wide enough to show that fill_pa keeps it unchanged. A memory model in the bench can hold back ready on two cycles out of three, which exercises the request hold rule while the address generator switches between levels.

// File: rtl/tbl_walker_pkg.sv
package tbl_walker_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_RD_OUTER,
      WS_WT_OUTER,
      WS_RD_INNER,
      WS_WT_INNER,
      WS_DONE,
      WS_FAULT
   } walk_st_e;

   localparam logic LVL_OUTER = 1'b0;
   localparam logic LVL_INNER = 1'b1;

endpackage

// File: rtl/tw_pte_decode.sv
module tw_pte_decode #(
   parameter int PTE_W  = 32,
   parameter int PFN_W  = 20,
   parameter int ATTR_W = 4
) (
   input  logic [PTE_W-1:0]  pte,
   output logic              present,
   output logic [PFN_W-1:0]  pfn,
   output logic [ATTR_W-1:0] attr
);
   localparam int GAP_W = PTE_W - PFN_W - ATTR_W - 1;

   assign present = pte[0];
   assign attr    = pte[ATTR_W:1];
   assign pfn     = pte[PTE_W-1 -: PFN_W];

   generate
      if (GAP_W > 0) begin : g_gap
         logic unused_gap;
         assign unused_gap = ^pte[ATTR_W+1 +: GAP_W];
      end
   endgenerate
endmodule

// File: rtl/tw_addr_gen.sv
module tw_addr_gen #(
   parameter int VA_W        = 32,
   parameter int L1_W        = 10,
   parameter int L2_W        = 10,
   parameter int PA_W        = 32,
   parameter int ENTRY_SHIFT = 2
) (
   input  logic [VA_W-1:0]                va,
   input  logic [PA_W-1:0]                outer_base,
   input  logic [PA_W-(VA_W-L1_W-L2_W)-1:0] inner_pfn,
   input  logic                           sel_inner,
   output logic [PA_W-1:0]                ent_addr
);
   localparam int OFF_W = VA_W - L1_W - L2_W;

   logic [PA_W-1:0] lvl_addr [2];

   generate
      for (genvar lvl = 0; lvl < 2; lvl++) begin : g_lvl
         localparam int IW  = (lvl == 0) ? L1_W : L2_W;
         localparam int LSB = (lvl == 0) ? OFF_W + L2_W : OFF_W;
         logic [PA_W-1:0] base_w;
         logic [PA_W-1:0] scaled_w;
         if (lvl == 0) begin : g_outer
            assign base_w = outer_base;
         end else begin : g_inner
            assign base_w = {inner_pfn, {OFF_W{1'b0}}};
         end
         assign scaled_w      = PA_W'(va[LSB +: IW]) << ENTRY_SHIFT;
         assign lvl_addr[lvl] = base_w + scaled_w;
      end
   endgenerate

   assign ent_addr = sel_inner ? lvl_addr[1] : lvl_addr[0];
endmodule

// File: rtl/tw_seq.sv
module tw_seq
   import tbl_walker_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int PFN_W  = 20,
   parameter int ATTR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VA_W-1:0]   miss_va,
   input  logic [PA_W-1:0]   root_base,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic              rsp_present,
   input  logic [PFN_W-1:0]  rsp_pfn,
   input  logic [ATTR_W-1:0] rsp_attr,
   output walk_st_e          st,
   output logic [VA_W-1:0]   va_q,
   output logic [PA_W-1:0]   base_q,
   output logic [PFN_W-1:0]  pfn_q,
   output logic [ATTR_W-1:0] attr_q,
   output logic              lvl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= WS_IDLE;
         va_q   <= '0;
         base_q <= '0;
         pfn_q  <= '0;
         attr_q <= '0;
         lvl_q  <= LVL_OUTER;
      end else begin
         case (st)
            WS_IDLE: begin
               if (miss_valid) begin
                  va_q   <= miss_va;
                  base_q <= root_base;
                  st     <= WS_RD_OUTER;
               end
            end
            WS_RD_OUTER: if (mem_req_ready) st <= WS_WT_OUTER;
            WS_WT_OUTER: begin
               if (mem_rsp_valid) begin
                  if (rsp_present) begin
                     pfn_q <= rsp_pfn;
                     st    <= WS_RD_INNER;
                  end else begin
                     lvl_q <= LVL_OUTER;
                     st    <= WS_FAULT;
                  end
               end
            end
            WS_RD_INNER: if (mem_req_ready) st <= WS_WT_INNER;
            WS_WT_INNER: begin
               if (mem_rsp_valid) begin
                  if (rsp_present) begin
                     pfn_q  <= rsp_pfn;
                     attr_q <= rsp_attr;
                     st     <= WS_DONE;
                  end else begin
                     lvl_q <= LVL_INNER;
                     st    <= WS_FAULT;
                  end
               end
            end
            WS_DONE:  st <= WS_IDLE;
            WS_FAULT: st <= WS_IDLE;
            default:  st <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
   import tbl_walker_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int L1_W   = 10,
   parameter int L2_W   = 10,
   parameter int PA_W   = 32,
   parameter int PTE_W  = 32,
   parameter int ATTR_W = 4,
   localparam int OFF_W = VA_W - L1_W - L2_W,
   localparam int PFN_W = PA_W - OFF_W,
   localparam int VPN_W = L1_W + L2_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VA_W-1:0]   miss_va,
   input  logic [PA_W-1:0]   root_base,
   output logic              busy,
   output logic              mem_req_valid,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic              fill_valid,
   output logic [VPN_W-1:0]  fill_vpn,
   output logic [PFN_W-1:0]  fill_pfn,
   output logic [ATTR_W-1:0] fill_attr,
   output logic [PA_W-1:0]   fill_pa,
   output logic              fault_valid,
   output logic [VA_W-1:0]   fault_va,
   output logic              fault_level
);
   localparam int ENTRY_BYTES = PTE_W / 8;
   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

   generate
      if (L1_W < 1 || L2_W < 1 || OFF_W < 1) begin : g_bad_split
         $error("tbl_walker: index and offset fields must each be non-empty");
      end
      if ((PTE_W % 8) != 0 || (ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_pte
         $error("tbl_walker: entry size must be a power-of-two byte count");
      end
      if (PFN_W < 1 || PFN_W + ATTR_W + 1 > PTE_W) begin : g_bad_fields
         $error("tbl_walker: frame, attribute and present fields do not fit an entry");
      end
   endgenerate

   walk_st_e          st;
   logic [VA_W-1:0]   va_q;
   logic [PA_W-1:0]   base_q;
   logic [PFN_W-1:0]  pfn_q;
   logic [ATTR_W-1:0] attr_q;
   logic              lvl_q;
   logic              rsp_present;
   logic [PFN_W-1:0]  rsp_pfn;
   logic [ATTR_W-1:0] rsp_attr;

   tw_pte_decode #(.PTE_W(PTE_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W)) u_dec (
      .pte     (mem_rsp_data),
      .present (rsp_present),
      .pfn     (rsp_pfn),
      .attr    (rsp_attr)
   );

   tw_seq #(.VA_W(VA_W), .PA_W(PA_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_valid    (miss_valid),
      .miss_va       (miss_va),
      .root_base     (root_base),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_present   (rsp_present),
      .rsp_pfn       (rsp_pfn),
      .rsp_attr      (rsp_attr),
      .st            (st),
      .va_q          (va_q),
      .base_q        (base_q),
      .pfn_q         (pfn_q),
      .attr_q        (attr_q),
      .lvl_q         (lvl_q)
   );

   tw_addr_gen #(.VA_W(VA_W), .L1_W(L1_W), .L2_W(L2_W), .PA_W(PA_W),
                 .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr (
      .va         (va_q),
      .outer_base (base_q),
      .inner_pfn  (pfn_q),
      .sel_inner  (st == WS_RD_INNER),
      .ent_addr   (mem_req_addr)
   );

   assign busy          = (st != WS_IDLE);
   assign mem_req_valid = (st == WS_RD_OUTER) || (st == WS_RD_INNER);
   assign fill_valid    = (st == WS_DONE);
   assign fill_vpn      = va_q[VA_W-1:OFF_W];
   assign fill_pfn      = pfn_q;
   assign fill_attr     = attr_q;
   assign fill_pa       = {pfn_q, va_q[OFF_W-1:0]};
   assign fault_valid   = (st == WS_FAULT);
   assign fault_va      = va_q;
   assign fault_level   = lvl_q;
endmodule

// File: rtl/tbl_walker_chk.sv
module tbl_walker_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            miss_valid,
   input logic            busy,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            fill_valid,
   input logic            fault_valid,
   input logic            fault_level
);
   logic [1:0] rd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rd_cnt <= '0;
      else if (!busy)                      rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3)
                                           rd_cnt <= rd_cnt + 2'd1;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && fault_valid)); // R9

   AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> !fill_valid && !busy); // R9

   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid && !busy); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid); // R7

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && miss_valid |=> busy && mem_req_valid); // R7

   AST_OUTER_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid && !fault_level |-> rd_cnt == 2'd1); // R5

   AST_INNER_FAULT_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid && fault_level |-> rd_cnt == 2'd2); // R6

   AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= 2'd2); // R7
endmodule

bind tbl_walker tbl_walker_chk #(.PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .miss_valid    (miss_valid),
   .busy          (busy),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .fill_valid    (fill_valid),
   .fault_valid   (fault_valid),
   .fault_level   (fault_level)
);

// File: tb/tbl_walker_tb_top.sv
module tbl_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_va = '0;
   logic [31:0] root_base = '0;
   logic        busy;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        fill_valid;
   logic [19:0] fill_vpn;
   logic [19:0] fill_pfn;
   logic [3:0]  fill_attr;
   logic [31:0] fill_pa;
   logic        fault_valid;
   logic [31:0] fault_va;
   logic        fault_level;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit stall_mode = 1'b0;
   int cyc = 0;
   int rd_total = 0;
   logic [31:0] rd_log [16];
   logic [31:0] mem [logic [31:0]];

   always #2 clk = ~clk;

   tbl_walker dut_i (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
      .root_base(root_base), .busy(busy), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
      .fill_attr(fill_attr), .fill_pa(fill_pa), .fault_valid(fault_valid),
      .fault_va(fault_va), .fault_level(fault_level)
   );

   assign mem_req_ready = !stall_mode || (cyc % 3 == 0);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
         rd_log[rd_total % 16] <= mem_req_addr;
         rd_total <= rd_total + 1;
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   function automatic logic [31:0] mk_pte(input logic [19:0] pfn, input logic [3:0] attr,
                                          input logic present);
      return {pfn, 7'b0, attr, present};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Starts a walk and waits for its result; returns reads made by this walk.
   task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                           input bit poke_busy, output int reads, output bit got);
      int start;
      start = rd_total;
      got = 1'b0;
      @(negedge clk);
      miss_va = va;
      root_base = base;
      miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
      root_base = 32'hDEAD_0000;
      chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
      if (poke_busy) begin
         miss_va = 32'hFFFF_F000;
         miss_valid = 1'b1;
         @(negedge clk);
         @(negedge clk);
         miss_valid = 1'b0;
      end
      for (int i = 0; i < 60 && !got; i++) begin
         if (fill_valid || fault_valid) got = 1'b1;
         else @(negedge clk);
      end
      reads = rd_total - start;
   endtask

   task automatic after_pulse(input string tag);
      @(negedge clk);
      chk(!fill_valid && !fault_valid && !busy, {"R9 pulse ends ", tag},
          64'({fill_valid, fault_valid, busy}), 64'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 reset quiet",
          64'({busy, mem_req_valid, fill_valid, fault_valid}), 64'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_success(input logic [31:0] va, input logic [31:0] base,
                            input logic [19:0] inner_pfn, input logic [19:0] pfn,
                            input logic [3:0] attr, input bit poke, input string tag);
      int reads;
      bit got;
      logic [31:0] a1, a2;
      a1 = base + {20'b0, va[31:22], 2'b00};
      a2 = {inner_pfn, 12'h000} + {20'b0, va[21:12], 2'b00};
      mem[a1] = mk_pte(inner_pfn, 4'hA, 1'b1);
      mem[a2] = mk_pte(pfn, attr, 1'b1);
      run_walk(va, base, poke, reads, got);
      chk(got && fill_valid && !fault_valid, {"R4 fill seen ", tag},
          64'({fill_valid, fault_valid}), 64'b10);
      chk(reads == 2, {"R7 read count ", tag}, 64'(reads), 64'd2);
      chk(rd_log[(rd_total - 2) % 16] == a1, {"R2 outer addr ", tag},
          64'(rd_log[(rd_total - 2) % 16]), 64'(a1));
      chk(rd_log[(rd_total - 1) % 16] == a2, {"R3 inner addr ", tag},
          64'(rd_log[(rd_total - 1) % 16]), 64'(a2));
      chk(fill_pfn == pfn && fill_attr == attr, {"R4 pfn/attr ", tag},
          64'({fill_pfn, fill_attr}), 64'({pfn, attr}));
      chk(fill_vpn == va[31:12], {"R4 vpn ", tag}, 64'(fill_vpn), 64'(va[31:12]));
      chk(fill_pa == {pfn, va[11:0]}, {"R4 pa ", tag}, 64'(fill_pa), 64'({pfn, va[11:0]}));
      after_pulse(tag);
   endtask

   task automatic t_fault_outer();
      int reads;
      bit got;
      logic [31:0] va = 32'h1234_5678;
      logic [31:0] base = 32'h0004_0000;
      mem[base + {20'b0, va[31:22], 2'b00}] = mk_pte(20'h77777, 4'hF, 1'b0);
      run_walk(va, base, 1'b0, reads, got);
      chk(got && fault_valid && !fill_valid, "R5 fault seen", 64'({fault_valid, fill_valid}), 64'b10);
      chk(fault_level == 1'b0, "R5 level", 64'(fault_level), 64'd0);
      chk(fault_va == va, "R5 va", 64'(fault_va), 64'(va));
      chk(reads == 1, "R5 single read", 64'(reads), 64'd1);
      after_pulse("outer fault");
   endtask

   task automatic t_fault_inner();
      int reads;
      bit got;
      logic [31:0] va = 32'h8765_4321;
      logic [31:0] base = 32'h0005_0000;
      mem[base + {20'b0, va[31:22], 2'b00}] = mk_pte(20'h00321, 4'h0, 1'b1);
      mem[{20'h00321, 12'h0} + {20'b0, va[21:12], 2'b00}] = mk_pte(20'hABCDE, 4'h5, 1'b0);
      run_walk(va, base, 1'b0, reads, got);
      chk(got && fault_valid && !fill_valid, "R6 fault seen", 64'({fault_valid, fill_valid}), 64'b10);
      chk(fault_level == 1'b1, "R6 level", 64'(fault_level), 64'd1);
      chk(fault_va == va, "R6 va", 64'(fault_va), 64'(va));
      chk(reads == 2, "R6 two reads", 64'(reads), 64'd2);
      after_pulse("inner fault");
   endtask

   initial begin
      t_reset();
      t_success(32'h0040_1ABC, 32'h0001_0000, 20'h00200, 20'h12345, 4'h9, 1'b0, "basic");
      t_success(32'hFFFF_FFFF, 32'h0002_0000, 20'h00300, 20'hFEDCB, 4'hF, 1'b0, "top index");
      t_success(32'h0000_0000, 32'h0003_0004, 20'h00400, 20'h00001, 4'h0, 1'b0, "zero index");
      t_fault_outer();
      t_fault_inner();
      stall_mode = 1'b1;
      t_success(32'h5555_5AAA, 32'h0006_0000, 20'h00500, 20'h0BEEF, 4'h3, 1'b0, "R8 stalled");
      stall_mode = 1'b0;
      t_success(32'h3210_0F0F, 32'h0007_0000, 20'h00600, 20'hC0FFE, 4'h6, 1'b1, "R7 miss while busy");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule